// File: doc/BRIEF.md
# Two-Way Cache Tag Model with Miss-Cause Labelling

This block models the tag side of a small two-way set-associative cache that is read only. Each cycle it may accept one 32-bit byte address. One cycle later it reports whether that reference hit. A miss is labelled with a single cause. A compulsory miss is the first reference ever made to a line. A conflict miss would have hit in a fully associative cache of the same size. A capacity miss would have missed even there. Data storage, writes, refill latency and backing memory are not modelled, so a line counts as present from the cycle after its miss.

The cache holds 512 bytes in 16 sets of two 16-byte lines. Address bits 3..0 select the byte within a line, bits 7..4 select the set, and bits 31..8 form the tag. Each set keeps one recency bit. The cause of a miss is found with two extra structures. The first is a 32-entry fully associative shadow cache with true LRU order, keyed on the line address (bits 31..4) and updated on every reference. The second is a record of every line address seen so far, with a parameter depth and a sticky flag that is raised when the record is full and a new line address has to be dropped. Running totals of references, hits and misses are output, so hit rate and miss rate can be derived.

There are two state machines. The result stage has two states. It moves from PH_IDLE to PH_REPORT when a request is accepted, stays in PH_REPORT while requests keep arriving, and returns to PH_IDLE on a cycle with no request. The seen-line record starts in HIST_FILLING and moves to HIST_SATURATED when its last free slot is written. It leaves HIST_SATURATED only on reset.

Top module: `cache_miss_classifier`

## Requirements
- R1: After reset the cache, the shadow and the seen-line record are all empty. res_valid, the three counters and hist_overflow read 0.
- R2: res_valid is 1 in exactly those cycles that directly follow a cycle with req_valid high. The hit flag and class then describe that request.
- R3: A reference hits when its set (bits 7..4) holds a valid way whose tag equals bits 31..8. Bits 3..0 play no part in hit detection.
- R4: On a miss the line is filled into an invalid way of the set, way 0 first. If both ways are valid, the less recently used way is replaced. A hit or a fill makes the other way of that set the less recently used one.
- R5: A miss to a line address that is not in the seen-line record reports class 1 (compulsory). The line address is then added to the record while it has room.
- R6: A miss to a line address that has been seen before reports class 2 (conflict) when the 32-entry fully associative LRU shadow holds that line.
- R7: A miss to a line address that has been seen before reports class 3 (capacity) when the shadow does not hold it. A hit always reports class 0.
- R8: Every accepted request adds one to ref_count, and adds one to either hit_count or miss_count, so ref_count always equals hit_count plus miss_count.
- R9: hist_overflow goes to 1 when a line address that is not in the record arrives while the record already holds HIST_DEPTH entries. It then stays at 1 until reset.
- R10: A cycle with req_valid low changes no counter and no cache, shadow or record state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A reference is presented this cycle |
| req_addr | input | 32 | Byte address of the reference |
| res_valid | output | 1 | Result of the previous cycle's reference is on the outputs |
| res_hit | output | 1 | 1 when that reference hit |
| res_class | output | 2 | 0 hit, 1 compulsory, 2 conflict, 3 capacity |
| ref_count | output | CNT_W | References accepted since reset |
| hit_count | output | CNT_W | Hits since reset |
| miss_count | output | CNT_W | Misses since reset |
| hist_overflow | output | 1 | Sticky: a new line address could not be recorded |

## Verification
The assertions assume that rst_n is held low for at least one clock edge. They also assume that req_addr is a known value whenever req_valid is high, because the recency and age updates follow the lookup of that address. The stimulus drives only defined addresses and lowers req_valid on idle cycles rather than leaving it undriven. It begins the run under reset, and it uses enough distinct lines to fill the seen-line record well before the run ends.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    typedef enum logic [1:0] {
        CLS_NONE       = 2'd0,
        CLS_COMPULSORY = 2'd1,
        CLS_CONFLICT   = 2'd2,
        CLS_CAPACITY   = 2'd3
    } miss_class_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_REPORT = 1'b1
    } phase_e;

    typedef enum logic {
        HIST_FILLING   = 1'b0,
        HIST_SATURATED = 1'b1
    } hist_state_e;
endpackage

// File: rtl/cmc_set_array.sv
module cmc_set_array #(
    parameter int SETS  = 16,
    parameter int TAG_W = 24,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    localparam int WAYS = 2;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  val_q [SETS];
    logic [SETS-1:0]  lru_q;
    logic [WAYS-1:0]  way_match;
    logic             use_way;

    for (genvar w = 0; w < WAYS; w++) begin : gen_way
        assign way_match[w] = val_q[idx][w] && (tag_q[idx][w] == tag);
    end
    assign hit = |way_match;

    always_comb begin
        if (way_match[0])         use_way = 1'b0;
        else if (way_match[1])    use_way = 1'b1;
        else if (!val_q[idx][0])  use_way = 1'b0;
        else if (!val_q[idx][1])  use_way = 1'b1;
        else                      use_way = lru_q[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
            for (int s = 0; s < SETS; s++) val_q[s] <= '0;
        end else if (upd_en) begin
            lru_q[idx] <= ~use_way;
            if (!hit) val_q[idx][use_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en && !hit) tag_q[idx][use_way] <= tag;
    end

    // A line may live in only one way of its set.
    assert_ways_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && val_q[idx] == 2'b11) |-> (tag_q[idx][0] != tag_q[idx][1]));
    assert_single_way_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> $onehot0(way_match));
endmodule

// File: rtl/cmc_shadow_lru.sv
module cmc_shadow_lru #(
    parameter int ENTRIES = 32,
    parameter int LINE_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [LINE_W-1:0] line,
    output logic              hit
);
    localparam int AGE_W = $clog2(ENTRIES);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

    logic              val_q  [ENTRIES];
    logic [LINE_W-1:0] line_q [ENTRIES];
    logic [AGE_W-1:0]  age_q  [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [AGE_W-1:0]  hit_age;

    always_comb begin
        hit_age = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hit_vec[i]) hit_age = hit_age | age_q[i];
    end
    assign hit = |hit_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : gen_ent
        assign hit_vec[i] = val_q[i] && (line_q[i] == line);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q[i] <= 1'b0;
                age_q[i] <= AGE_W'(i);
            end else if (upd_en) begin
                if (hit) begin
                    if (hit_vec[i])              age_q[i] <= '0;
                    else if (age_q[i] < hit_age) age_q[i] <= age_q[i] + 1'b1;
                end else if (age_q[i] == OLDEST) begin
                    age_q[i] <= '0;
                    val_q[i] <= 1'b1;
                end else begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (upd_en && !hit && age_q[i] == OLDEST) line_q[i] <= line;
        end
    end

    assert_shadow_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> $onehot0(hit_vec));
endmodule

// File: rtl/cmc_seen_history.sv
module cmc_seen_history
    import cmc_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LINE_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [LINE_W-1:0] line,
    output logic              seen,
    output logic              overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LINE_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0]  fill_q;
    logic              ovf_q;
    hist_state_e       state_q, state_d;
    logic              add_new;

    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if ((CNT_W'(i) < fill_q) && (mem_q[i] == line)) seen = 1'b1;
    end
    assign add_new  = upd_en && !seen;
    assign overflow = ovf_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HIST_FILLING:   if (add_new && fill_q == CNT_W'(DEPTH - 1)) state_d = HIST_SATURATED;
            HIST_SATURATED: state_d = HIST_SATURATED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HIST_FILLING;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            unique case (state_q)
                HIST_FILLING:   if (add_new) fill_q <= fill_q + 1'b1;
                HIST_SATURATED: if (add_new) ovf_q  <= 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == HIST_FILLING && add_new) mem_q[fill_q[PTR_W-1:0]] <= line;
    end

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    assert_no_overflow_while_filling_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HIST_FILLING) |-> !ovf_q);
    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/cache_miss_classifier.sv
module cache_miss_classifier
    import cmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFFSET_W   = 4,
    parameter int SETS       = 16,
    parameter int HIST_DEPTH = 64,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [1:0]        res_class,
    output logic [CNT_W-1:0]  ref_count,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic              hist_overflow
);
    localparam int IDX_W     = $clog2(SETS);
    localparam int TAG_W     = ADDR_W - OFFSET_W - IDX_W;
    localparam int LINE_W    = ADDR_W - OFFSET_W;
    localparam int SHADOW_N  = SETS * 2;

    logic [LINE_W-1:0] line;
    logic              set_hit, sh_hit, seen;
    miss_class_e       cls_d;
    phase_e            phase_q, phase_d;

    assign line = req_addr[ADDR_W-1:OFFSET_W];

    cmc_set_array #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_sets (
        .clk(clk), .rst_n(rst_n), .upd_en(req_valid),
        .idx(req_addr[OFFSET_W+IDX_W-1:OFFSET_W]),
        .tag(req_addr[ADDR_W-1:OFFSET_W+IDX_W]),
        .hit(set_hit)
    );

    cmc_shadow_lru #(.ENTRIES(SHADOW_N), .LINE_W(LINE_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .upd_en(req_valid), .line(line), .hit(sh_hit)
    );

    cmc_seen_history #(.DEPTH(HIST_DEPTH), .LINE_W(LINE_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .upd_en(req_valid), .line(line),
        .seen(seen), .overflow(hist_overflow)
    );

    always_comb begin
        if (set_hit)     cls_d = CLS_NONE;
        else if (!seen)  cls_d = CLS_COMPULSORY;
        else if (sh_hit) cls_d = CLS_CONFLICT;
        else             cls_d = CLS_CAPACITY;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (req_valid)  phase_d = PH_REPORT;
            PH_REPORT: if (!req_valid) phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign res_valid = (phase_q == PH_REPORT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hit    <= 1'b0;
            res_class  <= CLS_NONE;
            ref_count  <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else if (req_valid) begin
            res_hit   <= set_hit;
            res_class <= cls_d;
            ref_count <= ref_count + 1'b1;
            if (set_hit) hit_count  <= hit_count + 1'b1;
            else         miss_count <= miss_count + 1'b1;
        end
    end

    assert_result_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    assert_hit_unclassed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_class == CLS_NONE));
    assert_miss_classed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_class != CLS_NONE));
    assert_totals_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_count == hit_count + miss_count);
    assert_ref_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ref_count == $past(ref_count) + 1'b1);
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(ref_count));
endmodule

// File: tb/tb_cache_miss_classifier.sv
module tb_cache_miss_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int HDEPTH     = 64;
    localparam int SHN        = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        res_valid, res_hit, hist_overflow;
    logic [1:0]  res_class;
    logic [31:0] ref_count, hit_count, miss_count;

    cache_miss_classifier dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_class(res_class),
        .ref_count(ref_count), .hit_count(hit_count), .miss_count(miss_count),
        .hist_overflow(hist_overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // behavioural reference state
    logic [23:0] m_tag [16][2];
    bit          m_val [16][2];
    bit          m_lru [16];
    logic [27:0] sh_q [$];
    logic [27:0] hist_q [$];
    bit          e_valid, e_hit, e_ovf;
    int          e_class;
    int unsigned e_ref, e_hits, e_miss;
    int unsigned seed = 32'h1234_5678;

    function automatic int find_q(ref logic [27:0] q [$], input logic [27:0] v);
        foreach (q[i]) if (q[i] == v) return i;
        return -1;
    endfunction

    function automatic string cls_req(int c);
        case (c)
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic compare();
        vectors++;
        if (res_valid !== e_valid) begin
            miscompares++;
            $display("FAIL R2 res_valid actual=%0b expected=%0b", res_valid, e_valid);
        end
        if (e_valid && res_hit !== e_hit) begin
            miscompares++;
            $display("FAIL R3/R4 res_hit actual=%0b expected=%0b", res_hit, e_hit);
        end
        if (e_valid && res_class !== 2'(e_class)) begin
            miscompares++;
            $display("FAIL %s res_class actual=%0d expected=%0d", cls_req(e_class), res_class, e_class);
        end
        if (ref_count !== e_ref || hit_count !== e_hits || miss_count !== e_miss) begin
            miscompares++;
            $display("FAIL R8/R10 counters actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                     ref_count, hit_count, miss_count, e_ref, e_hits, e_miss);
        end
        if (hist_overflow !== e_ovf) begin
            miscompares++;
            $display("FAIL R9 hist_overflow actual=%0b expected=%0b", hist_overflow, e_ovf);
        end
    endtask

    // One cycle: check the previous result, then present the next input.
    task automatic step(bit v, logic [31:0] a);
        logic [27:0] ln;
        logic [3:0]  ix;
        logic [23:0] tg;
        int          w, p;
        bit          seen, shit;
        @(negedge clk);
        compare();
        req_valid = v;
        req_addr  = a;
        e_valid   = v;
        if (!v) return;   // R10: nothing changes on an idle cycle
        ln = a[31:4]; ix = a[7:4]; tg = a[31:8];
        w = -1;
        for (int k = 0; k < 2; k++) if (m_val[ix][k] && m_tag[ix][k] == tg) w = k;
        seen = (find_q(hist_q, ln) >= 0);
        shit = (find_q(sh_q, ln) >= 0);
        e_hit = (w >= 0);
        e_class = e_hit ? 0 : (!seen ? 1 : (shit ? 2 : 3));
        e_ref++;
        if (e_hit) e_hits++; else e_miss++;
        if (!e_hit) begin
            if (!m_val[ix][0]) w = 0;
            else if (!m_val[ix][1]) w = 1;
            else w = m_lru[ix];
            m_val[ix][w] = 1;
            m_tag[ix][w] = tg;
        end
        m_lru[ix] = (w == 0);
        p = find_q(sh_q, ln);
        if (p >= 0) sh_q.delete(p);
        else if (sh_q.size() == SHN) void'(sh_q.pop_back());
        sh_q.push_front(ln);
        if (!seen) begin
            if (hist_q.size() < HDEPTH) hist_q.push_back(ln);
            else e_ovf = 1;
        end
    endtask

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 16; s++) begin
            m_val[s][0] = 0; m_val[s][1] = 0; m_lru[s] = 0;
        end
        e_valid = 0; e_hit = 0; e_class = 0; e_ovf = 0;
        e_ref = 0; e_hits = 0; e_miss = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on the outputs
        vectors++;
        if (res_valid !== 1'b0 || ref_count !== 0 || hit_count !== 0 || miss_count !== 0 || hist_overflow !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset outputs actual=%0b/%0d/%0d/%0d/%0b expected=0/0/0/0/0",
                     res_valid, ref_count, hit_count, miss_count, hist_overflow);
        end
        // R3: byte offset does not affect the hit; first touch is R5 compulsory
        step(1, 32'h0000_0100);
        step(1, 32'h0000_0104);
        step(1, 32'h0000_010F);
        // R10: idle cycles
        step(0, 32'hDEAD_BEEF);
        step(0, 32'h0000_0100);
        // R4 and R6: three lines sharing set 5
        step(1, 32'h0000_1050);
        step(1, 32'h0000_2050);
        step(1, 32'h0000_1050);
        step(1, 32'h0000_3050);  // evicts 0x2050, the least recent
        step(1, 32'h0000_1050);  // still present
        step(1, 32'h0000_2050);  // conflict miss
        for (int r = 0; r < 3; r++) begin
            step(1, 32'h0000_1050);
            step(1, 32'h0000_2050);
            step(1, 32'h0000_3050);
        end
        // R7: cyclic sweep larger than the shadow gives capacity misses
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < 40; i++) step(1, 32'h0004_0000 + i * 16 + (r & 3));
        // mixed pattern with idles
        for (int i = 0; i < 300; i++) begin
            int unsigned rv = next_rand();
            step(rv[31:29] != 0, 32'h0005_0000 | (rv & 32'h1FF));
        end
        // R9: many new lines to exhaust the seen-line record, then keep going
        for (int i = 0; i < 90; i++) step(1, 32'h0100_0000 + i * 16);
        for (int i = 0; i < 20; i++) step(1, 32'h0000_1050 + i * 256);
        step(0, 32'h0);
        step(0, 32'h0);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule